// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synchronous single-port static memory with registered address and control inputs. A read passes through two register stages before its data reaches the shared bidirectional data bus. A write is self-timed: address, lane mask and bus data are captured on one clock edge and committed to the array on the next. The data word is split into byte lanes. A global write strobe writes every lane. Otherwise a byte-write strobe, together with one enable per lane, writes only the selected lanes.

An access starts when the address strobe is sampled while the device is selected. The device is selected only when three chip-select inputs agree. Within an access, an internal two-bit burst counter steps the low address bits while the advance input is asserted, and holds them while it is not. A static mode pin picks linear or interleaved stepping. The output enable gates the bus drivers without waiting for a clock. A power-down input releases the bus at once and blocks every access, and the stored contents are kept.

Top module: `sram_pipe_burst`

## Requirements
- R1: A read whose address is sampled with the strobe on edge n drives that word on `dq` after edge n+1. Between edges n and n+1, `dq` stays high impedance if the bus was idle before.
- R2: With `gwe_n` low on a write edge, all lanes of the word are written, whatever `bwe_n` and `lane_we_n` are.
- R3: With `gwe_n` high and `bwe_n` low, lane i (bits 8i+7:8i) is written only if `lane_we_n[i]` is low. With both `gwe_n` and `bwe_n` high, the cycle is a read and no lane is written.
- R4: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe sampled while it is not selected starts no access and writes nothing.
- R5: A strobe sampled while the device is not selected releases `dq` right after that same edge (a one-edge disable).
- R6: With `burst_lin`=1, each advance adds one to the two low address bits, modulo 4, from the strobed base.
- R7: With `burst_lin`=0, the two low address bits equal the base low bits XOR a counter that increments on each advance.
- R8: With `adv_n` high during an access, the same address is accessed again.
- R9: `oe_n` high puts `dq` in high impedance without a clock edge, and `oe_n` low restores the driven data.
- R10: `pdn` high releases `dq` at once, blocks reads and writes, and ends the current access. The stored contents are retained.
- R11: After an edge that samples a write, the device does not drive `dq`. The written data reads back afterwards.
- R12: After reset, `dq` is high impedance and no access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, sampled with the strobe |
| strobe | input | 1 | Address strobe: starts an access, or deselects when the chip is not selected |
| adv_n | input | 1 | Burst advance, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| gwe_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pdn | input | 1 | Power-down, active high |
| dq | inout | LANES*LW | Bidirectional data bus |

## Verification
The bench uses the default parameters: a 4-bit address (16 words) and four 8-bit lanes. With these values, a whole burst wrap of four words fits inside the array, and every lane-mask pattern can be applied to a single 32-bit word. Both burst orders are run from a base address whose low bits are not zero, so that wrap-around shows up within one burst. Byte-lane merges are checked against a word first written in full.

// File: rtl/sram_pkg.sv
// Shared constants and the burst address mixing function.
// Assumes a two-bit burst counter, as in a four-beat burst.
package sram_pkg;
    localparam int BURST_W = 2;

    // Combine base low bits with the beat count in linear or interleaved order.
    function automatic logic [BURST_W-1:0] burst_mix(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               lin
    );
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction
endpackage

// File: rtl/sram_burst_ctr.sv
// Burst address generator. It holds the strobed base address and a beat
// counter, and presents the address for the access taken on this edge.
// Assumes AW > BURST_W.
module sram_burst_ctr
    import sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          lin,
    input  logic [AW-1:0] base_in,
    output logic [AW-1:0] addr_nx
);
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;

    // Next beat count: restarts on load, steps on advance.
    always_comb begin
        cnt_nx = cnt_q;
        if (load)     cnt_nx = '0;
        else if (adv) cnt_nx = cnt_q + 1'b1;
    end

    // Address for the access being taken now.
    always_comb begin
        if (load) addr_nx = base_in;
        else      addr_nx = {base_q[AW-1:BURST_W],
                             burst_mix(base_q[BURST_W-1:0], cnt_nx, lin)};
    end

    // Burst base and counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) base_q <= base_in;
            cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/sram_lane_dec.sv
// Write-lane decode. The global write enable overrides the lane enables.
// The lane enables count only when the byte-write qualifier is active.
module sram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] mask,
    output logic             any
);
    // Priority: global write, then qualified per-lane writes.
    always_comb begin
        if (!gwe_n)      mask = '1;
        else if (!bwe_n) mask = ~lane_we_n;
        else             mask = '0;
        any = |mask;
    end
endmodule

// File: rtl/sram_array.sv
// Storage array, one memory per byte lane. Lane-masked synchronous write,
// combinational read. Contents are not reset, so they persist across power-down.
module sram_array #(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LANES-1:0]    mask,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Commit this lane when it is selected in the write mask.
        always_ff @(posedge clk) begin
            if (we && mask[g]) mem[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem[raddr];
    end
endmodule

// File: rtl/sram_pipe_burst.sv
// Pipelined burst SRAM top level. Stage 1 registers the access (address,
// type, lane mask, bus data). Stage 2 either commits a write or loads the
// output register and arms the bus drivers. Deselect, power-down and a new
// write disarm the drivers on the edge that samples them.
module sram_pipe_burst
    import sram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                strobe,
    input  logic                adv_n,
    input  logic                burst_lin,
    input  logic                ce1_n,
    input  logic                ce2,
    input  logic                ce3_n,
    input  logic                gwe_n,
    input  logic                bwe_n,
    input  logic [LANES-1:0]    lane_we_n,
    input  logic                oe_n,
    input  logic                pdn,
    inout  wire  [LANES*LW-1:0] dq
);
    localparam int DW = LANES * LW;

    logic             sel, start, stop, go, adv;
    logic             sess;
    logic [AW-1:0]    addr_nx;
    logic [LANES-1:0] mask;
    logic             wr_any;

    logic             acc_v, acc_wr;
    logic [AW-1:0]    acc_addr;
    logic [LANES-1:0] acc_mask;
    logic [DW-1:0]    acc_data;
    logic [DW-1:0]    rdata, out_q;
    logic             drive_q;

    // Access qualification from the chip selects, strobe and power-down.
    always_comb begin
        sel   = !ce1_n && ce2 && !ce3_n;
        start = strobe && sel && !pdn;
        stop  = pdn || (strobe && !sel);
        go    = start || (sess && !strobe && !pdn);
        adv   = sess && !strobe && !adv_n && !pdn;
    end

    sram_burst_ctr #(.AW(AW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .adv     (adv),
        .lin     (burst_lin),
        .base_in (addr),
        .addr_nx (addr_nx)
    );

    sram_lane_dec #(.LANES(LANES)) u_dec (
        .gwe_n     (gwe_n),
        .bwe_n     (bwe_n),
        .lane_we_n (lane_we_n),
        .mask      (mask),
        .any       (wr_any)
    );

    sram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
        .clk   (clk),
        .we    (acc_v && acc_wr),
        .mask  (acc_mask),
        .waddr (acc_addr),
        .wdata (acc_data),
        .raddr (acc_addr),
        .rdata (rdata)
    );

    // Access session and stage-1 control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess    <= 1'b0;
            acc_v   <= 1'b0;
            acc_wr  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            if (start)     sess <= 1'b1;
            else if (stop) sess <= 1'b0;
            acc_v   <= go;
            acc_wr  <= go && wr_any;
            drive_q <= acc_v && !acc_wr && !stop && !(go && wr_any);
        end
    end

    // Stage-1 address, mask and data-in registers; stage-2 output register.
    always_ff @(posedge clk) begin
        acc_addr <= addr_nx;
        acc_mask <= mask;
        acc_data <= dq;
        out_q    <= rdata;
    end

    assign dq = (drive_q && !oe_n && !pdn) ? out_q : {DW{1'bz}};
endmodule

// File: rtl/sram_pipe_burst_chk.sv
// Protocol checker bound to the SRAM top level. It relates the port inputs
// to the internal pipeline state.
module sram_pipe_burst_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe,
    input logic          adv_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          pdn,
    input logic          sess,
    input logic          acc_v,
    input logic          acc_wr,
    input logic [AW-1:0] acc_addr,
    input logic          drive_q
);
    logic unsel;
    assign unsel = strobe && !(!ce1_n && ce2 && !ce3_n);

    assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> $past(acc_v && !acc_wr));

    assert_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unsel |=> !acc_v);

    assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unsel |=> !drive_q);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sess && !strobe && adv_n && !pdn) |=> $stable(acc_addr));

    assert_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!acc_v && !sess));

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_v && acc_wr) |-> !drive_q);
endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .adv_n    (adv_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .pdn      (pdn),
    .sess     (sess),
    .acc_v    (acc_v),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .drive_q  (drive_q)
);

// File: tb/sram_pipe_burst_tb.sv
`timescale 1ns/1ps
module sram_pipe_burst_tb;
    localparam int AW = 4, LANES = 4, LW = 8, DW = 32;
    localparam logic [DW-1:0] HIZ = {DW{1'bz}};

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic strobe = 0, adv_n = 1, burst_lin = 1;
    logic ce1_n = 0, ce2 = 1, ce3_n = 0;
    logic gwe_n = 1, bwe_n = 1, oe_n = 0, pdn = 0;
    logic [LANES-1:0] lane_we_n = '1;
    logic tb_drv = 0;
    logic [DW-1:0] tb_data = '0;
    wire  [DW-1:0] dq;
    logic [DW-1:0] model [16];
    int n_chk = 0, n_fail = 0;
    logic done = 0;

    assign dq = tb_drv ? tb_data : HIZ;
    always #10 clk = ~clk;

    sram_pipe_burst #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .adv_n(adv_n),
        .burst_lin(burst_lin), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
        .pdn(pdn), .dq(dq)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle();
        strobe = 0; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gwe_n = 1; bwe_n = 1; lane_we_n = '1; oe_n = 0; pdn = 0; tb_drv = 0;
    endtask

    // End an access with a deselecting strobe.
    task automatic deselect();
        strobe = 1; ce1_n = 1; gwe_n = 1; bwe_n = 1; lane_we_n = '1; tb_drv = 0;
        cyc();
        idle();
    endtask

    // Single write cycle; the model follows R2/R3 lane rules.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic g, input logic b, input logic [LANES-1:0] l);
        idle();
        oe_n = 1; strobe = 1; addr = a; gwe_n = g; bwe_n = b; lane_we_n = l;
        tb_drv = 1; tb_data = d;
        cyc();
        for (int i = 0; i < LANES; i++)
            if (!g || (!b && !l[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
        deselect();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        idle();
        strobe = 1; addr = a;
        cyc();
        strobe = 0;
        cyc();
        d = dq;
        deselect();
    endtask

    task automatic t_reset();
        check(dq, HIZ, "R12 bus released after reset");
    endtask

    task automatic t_latency();
        logic [DW-1:0] d;
        wr(3, 32'h3C3C_0303, 0, 1, '1);
        idle(); strobe = 1; addr = 3;
        cyc();
        strobe = 0;
        check(dq, HIZ, "R1 no data one edge after strobe");
        cyc();
        check(dq, 32'h3C3C_0303, "R1 data two edges after strobe");
        deselect();
        rd(3, d);
        check(d, model[3], "R2 global write full word");
    endtask

    task automatic t_bytes();
        logic [DW-1:0] d;
        wr(4, 32'h1122_3344, 0, 0, 4'b0000);
        wr(4, 32'hAABB_CCDD, 1, 0, 4'b1010);
        rd(4, d);
        check(d, 32'h11BB_33DD, "R3 lanes 0 and 2 written");
        wr(4, 32'h0, 1, 1, 4'b0000);
        rd(4, d);
        check(d, 32'h11BB_33DD, "R3 no write without byte-write qualifier");
        wr(4, 32'hFFFF_FFFF, 0, 1, 4'b1111);
        rd(4, d);
        check(d, 32'hFFFF_FFFF, "R2 global write overrides lane enables");
    endtask

    task automatic t_select();
        logic [DW-1:0] d;
        wr(5, 32'h5555_5555, 0, 1, '1);
        for (int k = 0; k < 3; k++) begin
            idle(); oe_n = 1;
            strobe = 1; addr = 5; gwe_n = 0; tb_drv = 1; tb_data = 32'h0;
            ce1_n = (k == 0); ce2 = (k != 1); ce3_n = (k == 2);
            cyc();
            idle();
            cyc();
            check(dq, HIZ, "R4 unselected strobe starts no read");
        end
        rd(5, d);
        check(d, 32'h5555_5555, "R4 unselected write ignored");
    endtask

    task automatic t_deselect();
        idle(); strobe = 1; addr = 5;
        cyc();
        strobe = 0;
        cyc();
        check(dq, 32'h5555_5555, "R5 driven before deselect");
        strobe = 1; ce2 = 0;
        cyc();
        check(dq, HIZ, "R5 released one edge after deselect");
        idle();
    endtask

    task automatic t_burst(input logic lin, input logic [AW-1:0] base,
                           input logic [AW-1:0] e0, input logic [AW-1:0] e1,
                           input logic [AW-1:0] e2, input logic [AW-1:0] e3,
                           input string req);
        logic [AW-1:0] exp [4];
        exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
        idle(); burst_lin = lin; strobe = 1; addr = base;
        cyc();
        strobe = 0; adv_n = 0;
        for (int i = 0; i < 4; i++) begin
            cyc();
            check(dq, model[exp[i]], req);
        end
        deselect();
        burst_lin = 1;
    endtask

    task automatic t_hold();
        idle(); burst_lin = 1; strobe = 1; addr = 10;
        cyc();
        strobe = 0; adv_n = 1;
        cyc(); check(dq, model[10], "R8 first beat");
        cyc(); check(dq, model[10], "R8 held address");
        adv_n = 0;
        cyc(); check(dq, model[10], "R8 held before advance");
        cyc(); check(dq, model[11], "R8 advanced after hold");
        deselect();
    endtask

    task automatic t_oe();
        idle(); strobe = 1; addr = 8;
        cyc();
        strobe = 0;
        cyc();
        oe_n = 1; #2;
        check(dq, HIZ, "R9 output enable off without clock");
        oe_n = 0; #2;
        check(dq, model[8], "R9 output enable on without clock");
        deselect();
    endtask

    task automatic t_write_quiet();
        logic [DW-1:0] d;
        idle(); strobe = 1; addr = 9;
        cyc();
        strobe = 0;
        cyc();
        oe_n = 1; gwe_n = 0; tb_drv = 1; tb_data = 32'hC0DE_0009;
        cyc();
        model[9] = 32'hC0DE_0009;
        gwe_n = 1; tb_drv = 0; oe_n = 0;
        #1 check(dq, HIZ, "R11 bus not driven after write edge");
        cyc();
        cyc();
        check(dq, 32'hC0DE_0009, "R11 written word read back in burst");
        deselect();
        rd(9, d);
        check(d, 32'hC0DE_0009, "R11 written word read back");
    endtask

    task automatic t_pdn();
        logic [DW-1:0] d;
        idle(); strobe = 1; addr = 5;
        cyc();
        strobe = 0;
        cyc();
        pdn = 1; #2;
        check(dq, HIZ, "R10 bus released at power-down");
        oe_n = 1; strobe = 1; addr = 5; gwe_n = 0; tb_drv = 1; tb_data = 32'h0;
        cyc();
        strobe = 0; gwe_n = 1; tb_drv = 0;
        cyc();
        pdn = 0; oe_n = 0;
        cyc();
        check(dq, HIZ, "R10 access ended by power-down");
        rd(5, d);
        check(d, 32'h5555_5555, "R10 contents retained, write blocked");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_bytes();
        t_select();
        t_deselect();
        for (int i = 8; i < 12; i++) wr(i[AW-1:0], 32'hB000_0000 + i, 0, 1, '1);
        t_burst(1, 9, 9, 10, 11, 8, "R6 linear order");
        t_burst(0, 9, 9, 8, 11, 10, "R7 interleaved order base 1");
        t_burst(0, 10, 10, 11, 8, 9, "R7 interleaved order base 2");
        t_hold();
        t_oe();
        t_write_quiet();
        t_pdn();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule